// File: doc/BRIEF.md
# Three-Phase Instruction Sequencer for an 8-Bit Controller

This block is the control heart of a very small 8-bit controller, together with just enough datapath to be checked on its own. A program counter addresses an 8-bit-wide constant program memory. A phase machine walks every instruction through a fetch cycle, an optional operand cycle and an execute cycle, and then starts the next instruction. The operand cycle happens only for instructions that carry a second byte. Opcodes are decoded into datapath controls: the counter enable, the select of the value bus feeding the registers, and one load strobe per general register. There are four general registers, numbered 0 to 3.

Two load families exist. An immediate load takes its value from the program byte after the opcode. A port load takes its value from an 8-bit input port and has no second byte. Every other opcode executes as a two-cycle no-operation, so stray memory contents cannot corrupt the registers.

The program memory is a synchronous-read ROM whose image is computed from the address. Its read address is the program counter's next value, so the ROM output always shows the byte at the current counter value.

Top module: `mini_seq`

## Requirements
- R1: A synchronous active-high reset `rst` sets `pc` to 0, `phase` to fetch (2'd0), and all four registers to 0. While reset is held, no load strobe is active.
- R2: The phase encoding is 0 = fetch, 1 = operand, 2 = execute. Fetch is followed by operand when the fetched opcode is an immediate load (8'h10 to 8'h13), and by execute for any other opcode. Operand is always followed by execute, and execute by fetch.
- R3: `pc_en` is 1 in the fetch and operand phases and 0 in execute. `pc` advances by exactly 1 at each edge where `pc_en` is 1, and holds otherwise.
- R4: Opcode 8'h10 + k (k = 0..3) loads register k with the program byte at the address that follows the opcode.
- R5: Opcode 8'h18 + k (k = 0..3) loads register k, at the end of its execute cycle, with the `in_port` value present in that cycle. No operand byte is fetched.
- R6: `ld_en` is a one-cycle strobe that is active only in execute, has at most one bit set, and sets bit k for an opcode that loads register k.
- R7: Any opcode outside 8'h10..8'h13 and 8'h18..8'h1B takes exactly two cycles (fetch, execute) and changes no register.
- R8: `bus_sel` is 1 only in the execute cycle of a port load, which selects `in_port` onto the value bus. Otherwise it is 0, which selects the captured operand.
- R9: The ROM byte at address a is defined as follows. For odd a it is (29*a + 5) mod 256. For even a with bit 3 of a clear it is 8'h10 | a[2:1]. For even a with bit 3 set and bit 4 clear it is 8'h18 | a[2:1]. For even a with bits 3 and 4 set it is (53*a) mod 256.
- R10: The program counter wraps from 2^AW - 1 to 0 and skips no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_port | input | 8 | External input port, source for port loads |
| pc | output | AW | Program counter, address of the next byte to read |
| phase | output | 2 | Current phase: 0 fetch, 1 operand, 2 execute |
| pc_en | output | 1 | Program counter advance enable |
| bus_sel | output | 1 | Value bus select: 1 input port, 0 operand register |
| ld_en | output | 4 | One load strobe per general register |
| reg_a | output | 8 | General register 0 |
| reg_b | output | 8 | General register 1 |
| reg_c | output | 8 | General register 2 |
| reg_d | output | 8 | General register 3 |

## Verification
The assertions assume that `rst` is held for at least one clock edge before the first checked cycle, and that `in_port` is steady around the rising edge, since it feeds port loads directly. The stimulus asserts reset for several edges at the start and again in the middle of the run. It changes `in_port` only on the falling edge, to a fresh pattern every cycle. The run covers several complete wraps of the program counter, and the program image drifts between even and odd opcode alignment. As a result, every opcode class is fetched from both alignments.

// File: rtl/mini_seq_pkg.sv
`timescale 1ns/1ps
package mini_seq_pkg;

  localparam int DW   = 8;
  localparam int NREG = 4;
  localparam int RSW  = $clog2(NREG);

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_OPND  = 2'd1,
    PH_EXEC  = 2'd2
  } phase_e;

  // immediate loads occupy 0x10..0x13, port loads 0x18..0x1B
  localparam logic [DW-1:0] OP_IMM_BASE  = 8'h10;
  localparam logic [DW-1:0] OP_PORT_BASE = 8'h18;

  function automatic logic is_imm(input logic [DW-1:0] op);
    return op[DW-1:RSW] == OP_IMM_BASE[DW-1:RSW];
  endfunction

  function automatic logic is_port(input logic [DW-1:0] op);
    return op[DW-1:RSW] == OP_PORT_BASE[DW-1:RSW];
  endfunction

  // program image, computed from the address
  function automatic logic [DW-1:0] rom_image(input logic [15:0] a);
    logic [15:0] t;
    if (a[0]) begin
      t = a * 16'd29 + 16'd5;
    end else if (!a[3]) begin
      t = {8'h00, OP_IMM_BASE | {6'd0, a[2:1]}};
    end else if (!a[4]) begin
      t = {8'h00, OP_PORT_BASE | {6'd0, a[2:1]}};
    end else begin
      t = a * 16'd53;
    end
    return t[DW-1:0];
  endfunction

endpackage

// File: rtl/mini_seq_pc.sv
`timescale 1ns/1ps
module mini_seq_pc #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] pc_d
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    if (rst)     pc_d = '0;
    else if (en) pc_d = pc_q + ONE;
    else         pc_d = pc_q;
  end

  always_ff @(posedge clk) begin
    pc_q <= pc_d;
  end
endmodule

// File: rtl/mini_seq_rom.sv
`timescale 1ns/1ps
module mini_seq_rom
  import mini_seq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = rom_image(16'(i));
  end

  always_ff @(posedge clk) begin
    q <= mem[addr];
  end
endmodule

// File: rtl/mini_seq_ctrl.sv
`timescale 1ns/1ps
module mini_seq_ctrl
  import mini_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   rom_q,
  output logic [1:0]      phase,
  output logic            pc_en,
  output logic            opnd_we,
  output logic            bus_sel,
  output logic [NREG-1:0] ld_en
);
  phase_e        ph_q, ph_d;
  logic [DW-1:0] ir_q;
  logic          ir_load;

  // next phase depends on the current phase and the fetched opcode
  always_comb begin
    case (ph_q)
      PH_FETCH: ph_d = is_imm(rom_q) ? PH_OPND : PH_EXEC;
      PH_OPND:  ph_d = PH_EXEC;
      PH_EXEC:  ph_d = PH_FETCH;
      default:  ph_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_FETCH;
      ir_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (ph_q == PH_FETCH) ir_q <= rom_q;
    end
  end

  assign phase   = ph_q;
  assign pc_en   = (ph_q == PH_FETCH) || (ph_q == PH_OPND);
  assign opnd_we = (ph_q == PH_OPND);
  assign ir_load = (ph_q == PH_EXEC) && (is_imm(ir_q) || is_port(ir_q));
  assign bus_sel = (ph_q == PH_EXEC) && is_port(ir_q);

  for (genvar k = 0; k < NREG; k++) begin : g_ld
    assign ld_en[k] = ir_load && (ir_q[RSW-1:0] == RSW'(k));
  end
endmodule

// File: rtl/mini_seq_regs.sv
`timescale 1ns/1ps
module mini_seq_regs
  import mini_seq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     opnd_we,
  input  logic [DW-1:0]            rom_q,
  input  logic                     bus_sel,
  input  logic [DW-1:0]            in_port,
  input  logic [NREG-1:0]          ld_en,
  output logic [NREG-1:0][DW-1:0]  regs
);
  logic [DW-1:0] opnd_q;
  logic [DW-1:0] vbus;

  always_ff @(posedge clk) begin
    if (rst)          opnd_q <= '0;
    else if (opnd_we) opnd_q <= rom_q;
  end

  // value bus: a multiplexer, every branch assigned
  always_comb begin
    if (bus_sel) vbus = in_port;
    else         vbus = opnd_q;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           regs[k] <= '0;
      else if (ld_en[k]) regs[k] <= vbus;
    end
  end
endmodule

// File: rtl/mini_seq.sv
`timescale 1ns/1ps
module mini_seq
  import mini_seq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    in_port,
  output logic [AW-1:0] pc,
  output logic [1:0]    phase,
  output logic          pc_en,
  output logic          bus_sel,
  output logic [3:0]    ld_en,
  output logic [7:0]    reg_a,
  output logic [7:0]    reg_b,
  output logic [7:0]    reg_c,
  output logic [7:0]    reg_d
);
  logic [AW-1:0]           pc_d;
  logic [DW-1:0]           rom_q;
  logic                    opnd_we;
  logic [NREG-1:0][DW-1:0] regs;

  mini_seq_pc #(.AW(AW)) u_pc (
    .clk (clk), .rst (rst), .en (pc_en), .pc_q (pc), .pc_d (pc_d)
  );

  // read ahead on the next counter value so rom_q shows the byte at pc
  mini_seq_rom #(.AW(AW)) u_rom (
    .clk (clk), .addr (pc_d), .q (rom_q)
  );

  mini_seq_ctrl u_ctrl (
    .clk (clk), .rst (rst), .rom_q (rom_q), .phase (phase),
    .pc_en (pc_en), .opnd_we (opnd_we), .bus_sel (bus_sel), .ld_en (ld_en)
  );

  mini_seq_regs u_regs (
    .clk (clk), .rst (rst), .opnd_we (opnd_we), .rom_q (rom_q),
    .bus_sel (bus_sel), .in_port (in_port), .ld_en (ld_en), .regs (regs)
  );

  assign reg_a = regs[0];
  assign reg_b = regs[1];
  assign reg_c = regs[2];
  assign reg_d = regs[3];
endmodule

// File: rtl/mini_seq_chk.sv
`timescale 1ns/1ps
module mini_seq_chk
  import mini_seq_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] pc,
  input logic [1:0]    phase,
  input logic          pc_en,
  input logic          bus_sel,
  input logic [3:0]    ld_en,
  input logic [7:0]    reg_a,
  input logic [7:0]    reg_b,
  input logic [7:0]    reg_c,
  input logic [7:0]    reg_d
);
  localparam logic [AW-1:0] ONE = AW'(1);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && phase == PH_FETCH && ld_en == '0 &&
             reg_a == '0 && reg_b == '0 && reg_c == '0 && reg_d == '0));

  assert_opnd_then_exec_R2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_OPND |=> phase == PH_EXEC);

  assert_exec_then_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_EXEC |=> phase == PH_FETCH);

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    pc_en |=> pc == $past(pc) + ONE);

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !pc_en |=> $stable(pc));

  assert_pc_en_phase_R3: assert property (@(posedge clk) disable iff (rst)
    pc_en == (phase != PH_EXEC));

  assert_ld_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld_en));

  assert_ld_exec_only_R6: assert property (@(posedge clk) disable iff (rst)
    (ld_en != '0) |-> phase == PH_EXEC);

  assert_regs_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    phase != PH_EXEC |=> $stable({reg_a, reg_b, reg_c, reg_d}));

  assert_bus_sel_exec_R8: assert property (@(posedge clk) disable iff (rst)
    bus_sel |-> (phase == PH_EXEC && ld_en != '0));
endmodule

bind mini_seq mini_seq_chk #(.AW(AW)) u_chk (
  .clk (clk), .rst (rst), .pc (pc), .phase (phase), .pc_en (pc_en),
  .bus_sel (bus_sel), .ld_en (ld_en), .reg_a (reg_a), .reg_b (reg_b),
  .reg_c (reg_c), .reg_d (reg_d)
);

// File: tb/tb_mini_seq.sv
`timescale 1ns/1ps
module tb_mini_seq;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    in_port = 8'h00;
  logic [AW-1:0] pc;
  logic [1:0]    phase;
  logic          pc_en, bus_sel;
  logic [3:0]    ld_en;
  logic [7:0]    reg_a, reg_b, reg_c, reg_d;

  mini_seq #(.AW(AW)) dut (
    .clk (clk), .rst (rst), .in_port (in_port), .pc (pc), .phase (phase),
    .pc_en (pc_en), .bus_sel (bus_sel), .ld_en (ld_en),
    .reg_a (reg_a), .reg_b (reg_b), .reg_c (reg_c), .reg_d (reg_d)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int n_imm = 0, n_port = 0, n_nop = 0, n_wrap = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] m_pc, m_ir, m_opnd;
  logic [1:0] m_ph;
  logic [7:0] m_reg [4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // program byte per R9, computed arithmetically
  function automatic logic [7:0] prog_byte(input int a);
    if (a % 2 == 1)                 return 8'((29 * a + 5) % 256);
    if (((a / 8) % 2) == 0)         return 8'(16 + (a / 2) % 4);
    if (((a / 16) % 2) == 0)        return 8'(24 + (a / 2) % 4);
    return 8'((53 * a) % 256);
  endfunction

  function automatic int kind(input logic [7:0] op);
    if (op >= 8'h10 && op <= 8'h13) return 1;
    if (op >= 8'h18 && op <= 8'h1B) return 2;
    return 0;
  endfunction

  task automatic model_reset();
    m_pc = 0; m_ph = 2'd0; m_ir = 0; m_opnd = 0;
    for (int k = 0; k < 4; k++) m_reg[k] = 0;
  endtask

  task automatic check_reset_R1();
    chk(pc == 0,        "R1 pc",    int'(pc), 0);
    chk(phase == 2'd0,  "R1 phase", int'(phase), 0);
    chk(ld_en == 4'd0,  "R1 ld_en", int'(ld_en), 0);
    chk({reg_a, reg_b, reg_c, reg_d} == 32'd0, "R1 regs",
        int'({reg_a, reg_b, reg_c, reg_d}), 0);
  endtask

  task automatic compare_outputs();
    logic [3:0] e_ld;
    logic       e_sel;
    e_ld  = 4'd0;
    e_sel = 1'b0;
    if (m_ph == 2'd2 && kind(m_ir) != 0) e_ld = 4'b0001 << m_ir[1:0];
    if (m_ph == 2'd2 && kind(m_ir) == 2) e_sel = 1'b1;
    chk(pc == m_pc,   "R3 R10 pc", int'(pc), int'(m_pc));
    chk(phase == m_ph, "R2 phase", int'(phase), int'(m_ph));
    chk(pc_en == (m_ph != 2'd2), "R3 pc_en", int'(pc_en), int'(m_ph != 2'd2));
    chk(ld_en == e_ld, "R6 ld_en", int'(ld_en), int'(e_ld));
    chk(bus_sel == e_sel, "R8 bus_sel", int'(bus_sel), int'(e_sel));
    chk(reg_a == m_reg[0], "R4 R5 R7 reg_a", int'(reg_a), int'(m_reg[0]));
    chk(reg_b == m_reg[1], "R4 R5 R7 reg_b", int'(reg_b), int'(m_reg[1]));
    chk(reg_c == m_reg[2], "R4 R5 R7 reg_c", int'(reg_c), int'(m_reg[2]));
    chk(reg_d == m_reg[3], "R4 R5 R7 reg_d", int'(reg_d), int'(m_reg[3]));
  endtask

  // advance the model across one rising edge; in_port already updated
  task automatic model_step();
    logic [7:0] b;
    b = prog_byte(int'(m_pc));
    case (m_ph)
      2'd0: begin
        m_ir = b;
        m_ph = (kind(b) == 1) ? 2'd1 : 2'd2;
        if (m_pc == 8'hFF) n_wrap++;
        m_pc = m_pc + 8'd1;
      end
      2'd1: begin
        m_opnd = b;
        m_ph = 2'd2;
        if (m_pc == 8'hFF) n_wrap++;
        m_pc = m_pc + 8'd1;
      end
      default: begin
        case (kind(m_ir))
          1: begin m_reg[m_ir[1:0]] = m_opnd;  n_imm++;  end
          2: begin m_reg[m_ir[1:0]] = in_port; n_port++; end
          default: n_nop++;
        endcase
        m_ph = 2'd0;
      end
    endcase
  endtask

  task automatic run(input int cycles, input int seed);
    for (int c = 0; c < cycles; c++) begin
      compare_outputs();
      in_port = 8'((c * 113 + seed * 7 + (c >> 3)) % 256);
      model_step();
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_R1();
    model_reset();
    rst = 1'b0;
    run(3000, 1);
    // reset in mid program
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_R1();
    model_reset();
    rst = 1'b0;
    run(1500, 5);
    // the program must have exercised every class and the wrap
    chk(n_imm > 0,  "R4 immediate loads seen", n_imm, 1);
    chk(n_port > 0, "R5 port loads seen", n_port, 1);
    chk(n_nop > 0,  "R7 no-operations seen", n_nop, 1);
    chk(n_wrap > 0, "R10 pc wraps seen", n_wrap, 1);
    chk(prog_byte(0) == 8'h10, "R9 first byte", int'(prog_byte(0)), 16);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule